// File: doc/BRIEF.md
# Event-Based Branch Control Unit

This unit holds the user-level event-branch state of a 64-bit core: a status and control word, a return-address register and a handler-address register. Every cycle it looks at two event inputs (external and performance-monitor) and at the instruction being executed. When an enabled event arrives while branching is globally enabled, it diverts fetch to the handler address. It also records where execution would have continued, drops the global enable and marks which events occurred. When the return-from-event instruction executes, it sends fetch back to the saved address and sets or clears the global enable from the instruction's S bit.

The redirect request, its target and the illegal-instruction flag are combinational from the present register contents and inputs. Register updates land on the next rising clock edge. Software reaches the three registers through a simple select/write/read port. The status word uses big-endian bit numbering, where bit 0 is the most significant bit of the 64-bit word.

Top module: `ebb_ctrl_unit`

## Requirements
- R1: After reset all three registers read as zero, `redir_valid` is 0 and `illegal_insn` is 0.
- R2: `reg_sel` 0 selects status, 1 selects return address and 2 selects handler address. A write takes effect at the clock edge and `reg_rdata` shows the selected register combinationally. Select 3 reads zero and writes to it are ignored. The two low bits of the return and handler registers always read zero.
- R3: Status fields, numbered big-endian, map to `reg_wdata` bits as follows: global enable is bit 0 (data[63]). External enable is bit 30 (data[33]). Monitor enable is bit 31 (data[32]). External occurred is bit 62 (data[1]). Monitor occurred is bit 63 (data[0]). Reserved bits 32–33 are data[31:30].
- R4: An event is taken in the cycle it arrives if global enable is 1 and that event's enable bit is 1. In that cycle `redir_valid` is 1 and `redir_target` equals the handler register.
- R5: After a taken event, global enable is 0 and the occurred bit of each arriving enabled event is 1. The return register then holds `nia` with its two low bits cleared. Other status bits are unchanged.
- R6: An event whose enable bit is 0, or any event while global enable is 0, gives no redirect and changes no register.
- R7: When both events arrive enabled in the same cycle, exactly one redirect to the handler occurs and both occurred bits are set.
- R8: An instruction with `insn_valid` is the return instruction when insn[31:26]=010011 and insn[10:1]=0010010010; S is insn[11] and all other bits are ignored. It redirects to the return register. Any other encoding has no effect.
- R9: A return instruction that completes sets global enable to S and leaves every other status bit unchanged.
- R10: If status reserved bits 32–33 are not both zero, the return instruction raises `illegal_insn` for that cycle. There is no redirect and global enable is unchanged.
- R11: With `mode64` at 0 the return target has its upper 32 bits forced to zero.
- R12: A taken event in the same cycle as a return instruction wins. The redirect goes to the handler, the return instruction has no effect and raises no illegal flag.
- R13: A status write in the same cycle as a taken event stores the written value, except that global enable is cleared and the arriving occurred bits are set on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| ext_evt | input | 1 | External event arrives this cycle |
| pm_evt | input | 1 | Performance-monitor event arrives this cycle |
| nia | input | 64 | Address that would execute next without a branch |
| mode64 | input | 1 | 1 when the core runs in 64-bit mode |
| insn_valid | input | 1 | `insn` is executing this cycle |
| insn | input | 32 | Instruction word |
| redir_valid | output | 1 | Fetch redirect request |
| redir_target | output | 64 | Redirect address, zero when no redirect |
| illegal_insn | output | 1 | Return instruction is an invalid form |

## Verification
An arriving enabled event and an executing return instruction can fall in the same cycle. A register write can also coincide with a taken event. The bench provokes both. It presents an enabled external event together with a return instruction whose S bit is 1 and whose reserved status bits are set. It then checks that the handler target wins, that no illegal flag appears and that global enable stays 0 afterwards. It also writes the status word in the very cycle an event is taken. Reading the status back then must show the written bits with global enable cleared and the occurred bit merged in.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

    localparam int XLEN   = 64;
    localparam int INSN_W = 32;
    localparam int SEL_W  = 2;

    // status field positions, big-endian numbering (0 = MSB)
    localparam int BE_GE      = 0;
    localparam int BE_EXT_EN  = 30;
    localparam int BE_PM_EN   = 31;
    localparam int BE_RSV_LO  = 32;
    localparam int BE_RSV_HI  = 33;
    localparam int BE_EXT_OCC = 62;
    localparam int BE_PM_OCC  = 63;

    // instruction fields, big-endian numbering within the word
    localparam int BE_PO_LO = 0;
    localparam int BE_PO_HI = 5;
    localparam int BE_S     = 20;
    localparam int BE_XO_LO = 21;
    localparam int BE_XO_HI = 30;

    localparam logic [5:0] RET_PO = 6'b010011;
    localparam logic [9:0] RET_XO = 10'b0010010010;

    // number of low address bits that are always zero
    localparam int ALIGN_BITS = 2;

    function automatic int le64(input int be);
        return XLEN - 1 - be;
    endfunction

    function automatic int le32(input int be);
        return INSN_W - 1 - be;
    endfunction

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_RETURN  = 2'd1,
        SEL_HANDLER = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] ret_addr;
        logic [XLEN-1:0] hdl_addr;
    } ebb_state_t;

endpackage

// File: rtl/ebb_event_gate.sv
module ebb_event_gate
    import ebb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] status,
    input  logic            ext_evt,
    input  logic            pm_evt,
    output logic            take,
    output logic            occ_ext,
    output logic            occ_pm
);

    localparam int GE_I  = le64(BE_GE);
    localparam int EXT_I = le64(BE_EXT_EN);
    localparam int PM_I  = le64(BE_PM_EN);

    logic ext_hit;
    logic pm_hit;

    always_comb begin
        ext_hit = ext_evt && status[EXT_I];
        pm_hit  = pm_evt && status[PM_I];
        take    = status[GE_I] && (ext_hit || pm_hit);
        occ_ext = take && ext_hit;
        occ_pm  = take && pm_hit;
    end

    // R6
    gate_needs_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> status[GE_I]);

    // R4
    gate_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (occ_ext || occ_pm));

endmodule

// File: rtl/ebb_return_unit.sv
module ebb_return_unit
    import ebb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   status,
    input  logic [XLEN-1:0]   ret_addr,
    input  logic              mode64,
    input  logic              suppress,
    output logic              ret_ok,
    output logic              ret_s,
    output logic              illegal,
    output logic [XLEN-1:0]   target
);

    localparam int PO_HI_I  = le32(BE_PO_LO);
    localparam int PO_LO_I  = le32(BE_PO_HI);
    localparam int XO_HI_I  = le32(BE_XO_LO);
    localparam int XO_LO_I  = le32(BE_XO_HI);
    localparam int S_I      = le32(BE_S);
    localparam int RSV_HI_I = le64(BE_RSV_LO);
    localparam int RSV_LO_I = le64(BE_RSV_HI);
    localparam int HALF     = XLEN / 2;

    logic match;
    logic rsv_bad;
    logic exec;
    logic unused_insn;

    assign unused_insn = ^{insn[S_I+9:S_I+1], insn[0]};

    always_comb begin
        match   = insn_valid
                  && (insn[PO_HI_I:PO_LO_I] == RET_PO)
                  && (insn[XO_HI_I:XO_LO_I] == RET_XO);
        rsv_bad = |status[RSV_HI_I:RSV_LO_I];
        exec    = match && !suppress;
        illegal = exec && rsv_bad;
        ret_ok  = exec && !rsv_bad;
        ret_s   = insn[S_I];
        if (mode64) begin
            target = ret_addr;
        end else begin
            target = {{HALF{1'b0}}, ret_addr[HALF-1:0]};
        end
    end

    // R10
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && ret_ok));

    // R11
    narrow_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ok && !mode64) |-> (target[XLEN-1:HALF] == '0));

endmodule

// File: rtl/ebb_ctrl_unit.sv
module ebb_ctrl_unit
    import ebb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    input  logic              ext_evt,
    input  logic              pm_evt,
    input  logic [XLEN-1:0]   nia,
    input  logic              mode64,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_target,
    output logic              illegal_insn
);

    localparam int GE_I      = le64(BE_GE);
    localparam int EXT_OCC_I = le64(BE_EXT_OCC);
    localparam int PM_OCC_I  = le64(BE_PM_OCC);
    localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    ebb_state_t st_d, st_q;

    logic            take, occ_ext, occ_pm;
    logic            ret_ok, ret_s, ret_illegal;
    logic [XLEN-1:0] ret_target;
    reg_sel_e        sel;

    assign sel = reg_sel_e'(reg_sel);

    ebb_event_gate i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (st_q.status),
        .ext_evt (ext_evt),
        .pm_evt  (pm_evt),
        .take    (take),
        .occ_ext (occ_ext),
        .occ_pm  (occ_pm)
    );

    ebb_return_unit i_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .insn       (insn),
        .status     (st_q.status),
        .ret_addr   (st_q.ret_addr),
        .mode64     (mode64),
        .suppress   (take),
        .ret_ok     (ret_ok),
        .ret_s      (ret_s),
        .illegal    (ret_illegal),
        .target     (ret_target)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr_en) begin
            case (sel)
                SEL_STATUS:  st_d.status   = reg_wdata;
                SEL_RETURN:  st_d.ret_addr = reg_wdata & ALIGN_MASK;
                SEL_HANDLER: st_d.hdl_addr = reg_wdata & ALIGN_MASK;
                default:     ;
            endcase
        end
        if (take) begin
            st_d.status[GE_I] = 1'b0;
            if (occ_ext) st_d.status[EXT_OCC_I] = 1'b1;
            if (occ_pm)  st_d.status[PM_OCC_I]  = 1'b1;
            st_d.ret_addr = nia & ALIGN_MASK;
        end else if (ret_ok) begin
            st_d.status[GE_I] = ret_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_STATUS:  reg_rdata = st_q.status;
            SEL_RETURN:  reg_rdata = st_q.ret_addr;
            SEL_HANDLER: reg_rdata = st_q.hdl_addr;
            default:     reg_rdata = '0;
        endcase
        redir_valid  = take || ret_ok;
        if (take) begin
            redir_target = st_q.hdl_addr;
        end else if (ret_ok) begin
            redir_target = ret_target;
        end else begin
            redir_target = '0;
        end
        illegal_insn = ret_illegal;
    end

    // R5
    ge_clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.status[GE_I]);

    // R5
    ret_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.ret_addr == {$past(nia[XLEN-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}}));

    // R7
    both_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && occ_ext && occ_pm) |=> (st_q.status[EXT_OCC_I] && st_q.status[PM_OCC_I]));

    // R9
    ret_sets_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> (st_q.status[GE_I] == $past(ret_s)));

    // R10
    illegal_keeps_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_insn && !reg_wr_en) |=> $stable(st_q.status[GE_I]));

    // R12
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!illegal_insn && redir_valid && redir_target == st_q.hdl_addr));

    // R2
    aligned_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ret_addr[ALIGN_BITS-1:0] == '0) && (st_q.hdl_addr[ALIGN_BITS-1:0] == '0));

endmodule

// File: tb/test_ebb_ctrl_unit.sv
module test_ebb_ctrl_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        ext_evt = 1'b0;
    logic        pm_evt = 1'b0;
    logic [63:0] nia = '0;
    logic        mode64 = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        redir_valid;
    logic [63:0] redir_target;
    logic        illegal_insn;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ebb_ctrl_unit i_ebb_ctrl_unit (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_evt(ext_evt), .pm_evt(pm_evt), .nia(nia), .mode64(mode64),
        .insn_valid(insn_valid), .insn(insn),
        .redir_valid(redir_valid), .redir_target(redir_target), .illegal_insn(illegal_insn)
    );

    localparam logic [63:0] GE  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] EE  = 64'h0000_0002_0000_0000;
    localparam logic [63:0] PE  = 64'h0000_0001_0000_0000;
    localparam logic [63:0] EO  = 64'h0000_0000_0000_0002;
    localparam logic [63:0] PO  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] RSV = 64'h0000_0000_4000_0000;
    localparam logic [31:0] RET_S1 = 32'h4C00_0924;
    localparam logic [31:0] RET_S0 = 32'h4C00_0124;

    typedef struct packed {
        logic [31:0] tag;
        logic [63:0] st;
        logic [63:0] hdl;
        logic [63:0] ret;
        logic [63:0] nia;
        logic        m64;
        logic        ext;
        logic        pm;
        logic        iv;
        logic [31:0] insn;
        logic        e_rv;
        logic [63:0] e_tgt;
        logic        e_ill;
        logic [63:0] e_st;
        logic [63:0] e_ret;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{"R4  ", GE|EE, 64'h1000, 64'h0, 64'h2004, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,
          1'b1, 64'h1000, 1'b0, EE|EO, 64'h2004},
        '{"R5  ", GE|PE, 64'hFFFF_0000_0000_4000, 64'h0, 64'h3007, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,
          1'b1, 64'hFFFF_0000_0000_4000, 1'b0, PE|PO, 64'h3004},
        '{"R6  ", GE|PE, 64'h4000, 64'h55500, 64'h3000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,
          1'b0, 64'h0, 1'b0, GE|PE, 64'h55500},
        '{"R6  ", EE|PE, 64'h4000, 64'h55500, 64'h3000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,
          1'b0, 64'h0, 1'b0, EE|PE, 64'h55500},
        '{"R7  ", GE|EE|PE, 64'h8000, 64'h0, 64'h7008, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,
          1'b1, 64'h8000, 1'b0, EE|PE|EO|PO, 64'h7008},
        '{"R9  ", EO, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, RET_S1,
          1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, GE|EO, 64'h1234_5678_9ABC_DEF0},
        '{"R9  ", GE|EE, 64'h0, 64'h0000_0000_0000_4440, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, RET_S0,
          1'b1, 64'h4440, 1'b0, EE, 64'h4440},
        '{"R11 ", GE, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, RET_S0,
          1'b1, 64'h0000_0000_9ABC_DEF0, 1'b0, 64'h0, 64'h1234_5678_9ABC_DEF0},
        '{"R10 ", GE|RSV, 64'h0, 64'h5000, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, RET_S0,
          1'b0, 64'h0, 1'b1, GE|RSV, 64'h5000},
        '{"R10 ", RSV<<1, 64'h0, 64'h5000, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, RET_S1,
          1'b0, 64'h0, 1'b1, RSV<<1, 64'h5000},
        '{"R8  ", GE, 64'h0, 64'h6000, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h4C00_0126,
          1'b0, 64'h0, 1'b0, GE, 64'h6000},
        '{"R8  ", GE, 64'h0, 64'h6000, 64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h4C1F_F125,
          1'b1, 64'h6000, 1'b0, 64'h0, 64'h6000},
        '{"R12 ", GE|EE|RSV, 64'h9000, 64'hA000, 64'hB00C, 1'b1, 1'b1, 1'b0, 1'b1, RET_S1,
          1'b1, 64'h9000, 1'b0, EE|RSV|EO, 64'hB00C}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] data);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [63:0] data);
        reg_sel = sel;
        #0.5;
        data = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        rd(2'd0, r); check("R1 status", r, 64'h0);
        rd(2'd1, r); check("R1 return", r, 64'h0);
        rd(2'd2, r); check("R1 handler", r, 64'h0);
        check("R1 redirect", {63'h0, redir_valid}, 64'h0);
        check("R1 illegal", {63'h0, illegal_insn}, 64'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = $sformatf("%s v%0d", v.tag, i);
            wr(2'd0, v.st);
            wr(2'd1, v.ret);
            wr(2'd2, v.hdl);
            nia = v.nia; mode64 = v.m64; ext_evt = v.ext; pm_evt = v.pm;
            insn_valid = v.iv; insn = v.insn;
            #0.5;
            check({t, " redir_valid"}, {63'h0, redir_valid}, {63'h0, v.e_rv});
            if (v.e_rv) check({t, " target"}, redir_target, v.e_tgt);
            check({t, " illegal"}, {63'h0, illegal_insn}, {63'h0, v.e_ill});
            @(posedge clk);
            #1;
            ext_evt = 1'b0; pm_evt = 1'b0; insn_valid = 1'b0; mode64 = 1'b1;
            rd(2'd0, r); check({t, " status after"}, r, v.e_st);
            rd(2'd1, r); check({t, " return after"}, r, v.e_ret);
            rd(2'd2, r); check({t, " handler after"}, r, v.hdl);
        end

        // R2 select 3 reads zero, writes ignored, alignment
        wr(2'd0, 64'h0);
        wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd3, r); check("R2 sel3 read", r, 64'h0);
        rd(2'd0, r); check("R2 sel3 write ignored", r, 64'h0);
        wr(2'd1, 64'h1234_0000_0000_00FF);
        rd(2'd1, r); check("R2 return align", r, 64'h1234_0000_0000_00FC);
        wr(2'd2, 64'h0000_0000_0000_0003);
        rd(2'd2, r); check("R2 handler align", r, 64'h0);

        // R3 field map: pm enable alone at data[32] takes pm event
        wr(2'd0, GE | PE);
        wr(2'd2, 64'hC000);
        pm_evt = 1'b1;
        #0.5;
        check("R3 pm enable bit", {63'h0, redir_valid}, 64'h1);
        @(posedge clk);
        #1;
        pm_evt = 1'b0;
        rd(2'd0, r); check("R3 pm occurred bit", r, PE | PO);

        // R13 status write concurrent with taken event
        wr(2'd0, GE | EE);
        reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = GE | EE | 64'h10;
        ext_evt = 1'b1; nia = 64'hD000;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; ext_evt = 1'b0;
        rd(2'd0, r); check("R13 merged status", r, EE | EO | 64'h10);
        rd(2'd1, r); check("R13 return loaded", r, 64'hD000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule